// File: doc/BRIEF.md
# Pipeline Hazard and Branch Control Unit

This block is the steering logic for a five-stage in-order processor pipeline (fetch, decode, execute, memory, writeback). It owns the program counter and the decode-stage equality comparator. Conditional branches and jumps are resolved while they sit in decode, and the new PC is loaded on the edge that ends that cycle. The instruction fetched right behind a branch or jump, the delay slot, is never squashed: it always runs to completion.

Each cycle the surrounding datapath gives the block the register numbers and control flags held in the decode, execute, memory and writeback pipeline registers. It also gives the two operand values read from the register file in decode and the ALU result held in the memory stage. From these the block produces:

- the next-PC source;
- a stall that freezes the PC and the fetch/decode register;
- a bubble request that clears the execute-stage control flags;
- operand-source selects for the execute-stage multiplexers;
- selects for the comparator inputs.

ALU-to-ALU dependencies are covered entirely by forwarding. Only a consumer right behind a load, or a branch whose operand is not ready yet, causes a stall. The register file writes in the first half of the cycle and reads in the second half, so a value in writeback reaches decode without any help from this block.

Top module: `pipe_ctl`

## Requirements
- R1: A clock edge with `rst_n` low sets `pc` to 0.
- R2: When there is no stall, branch or jump, `next_sel` is 0 and `pc` advances by 4 on each edge.
- R3: A branch in decode with `id_branch_ne`=0 is taken when its two operands are equal. With `id_branch_ne`=1 it is taken when they differ. A taken branch drives `next_sel`=1 and `branch_taken`=1, and on the next edge loads `pc` + (sign-extended `id_imm` << 2). Here `pc` is the delay-slot address held in the PC register.
- R4: A branch that is not taken gives `next_sel`=0 and lets `pc` advance by 4. No branch outcome, taken or not, raises `bubble`, so the delay slot always completes.
- R5: A jump in decode drives `next_sel`=2 and loads `pc` with {upper 4 bits of `pc`, `id_jidx`, 2'b00}.
- R6: If a load in execute writes a nonzero register that decode reads through a used source, `stall` and `bubble` are both 1 and `pc` holds its value.
- R7: A branch in decode stalls while a source register matches a nonzero destination of either an instruction in execute that writes, or a load in the memory stage. As a result it waits one cycle behind an ALU producer and two cycles behind a load.
- R8: A non-load memory-stage result whose nonzero destination matches a branch source is sent to the comparator. The matching `cmp_fwd_a`/`cmp_fwd_b` bit is then 1 and `mem_result` replaces the register-file value.
- R9: `fwd_a`/`fwd_b` select the source for the execute-stage `ex_rs`/`ex_rt` operands: 0 is the register file, 1 is the memory stage and 2 is writeback. The memory stage wins when both match.
- R10: Register 0 never produces a forwarding select or a comparator forward, and never causes a stall.
- R11: While `stall` is 1, `next_sel` is 0, `branch_taken` is 0 and the PC is not redirected, even if a branch condition holds.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| id_rs | input | 5 | Decode first source register |
| id_rt | input | 5 | Decode second source register |
| id_use_rs | input | 1 | Decode instruction reads `id_rs` |
| id_use_rt | input | 1 | Decode instruction reads `id_rt` |
| id_is_branch | input | 1 | Decode holds a conditional branch |
| id_branch_ne | input | 1 | Branch condition is inequality (0 = equality) |
| id_is_jump | input | 1 | Decode holds an unconditional jump |
| id_imm | input | 16 | Branch word offset, signed |
| id_jidx | input | 26 | Jump word index |
| id_rs_data | input | 32 | Register-file value for `id_rs` |
| id_rt_data | input | 32 | Register-file value for `id_rt` |
| ex_rs | input | 5 | Execute first source register |
| ex_rt | input | 5 | Execute second source register |
| ex_rd | input | 5 | Execute destination register |
| ex_wen | input | 1 | Execute instruction writes a register |
| ex_load | input | 1 | Execute instruction is a load |
| mem_rd | input | 5 | Memory-stage destination register |
| mem_wen | input | 1 | Memory-stage instruction writes a register |
| mem_load | input | 1 | Memory-stage instruction is a load |
| mem_result | input | 32 | ALU result held in the memory stage |
| wb_rd | input | 5 | Writeback destination register |
| wb_wen | input | 1 | Writeback instruction writes a register |
| pc | output | 32 | Current fetch address |
| next_sel | output | 2 | Next-PC source: 0 sequential, 1 branch, 2 jump |
| stall | output | 1 | Hold PC and fetch/decode register |
| bubble | output | 1 | Clear execute-stage control flags |
| fwd_a | output | 2 | Execute first operand source |
| fwd_b | output | 2 | Execute second operand source |
| cmp_fwd_a | output | 1 | Comparator first input takes `mem_result` |
| cmp_fwd_b | output | 1 | Comparator second input takes `mem_result` |
| branch_taken | output | 1 | Branch in decode redirects this cycle |

## Verification
The hardest case to reach is a branch that waits behind a load. The load has to be in execute in one cycle and in the memory stage in the next, with the stall holding the PC through both cycles. In the third cycle the value comes through the register file, and the branch must resolve and redirect. The bench drives this sequence one cycle at a time, since it models the upstream pipeline registers through the ports, and checks the PC after every edge. Small register-number sweeps cover every match and priority pattern of the hazard and forwarding logic, including register 0.

// File: rtl/pipe_ctl_pkg.sv
// Shared encodings for the pipeline control unit.
// Assumes: all users compare against these values only through the typedefs.
package pipe_ctl_pkg;

    typedef enum logic [1:0] {
        NS_SEQ  = 2'd0,
        NS_BR   = 2'd1,
        NS_JUMP = 2'd2
    } next_sel_e;

    typedef enum logic [1:0] {
        SRC_RF  = 2'd0,
        SRC_MEM = 2'd1,
        SRC_WB  = 2'd2
    } src_sel_e;

endpackage

// File: rtl/hz_detect.sv
// Stall detector: load-use interlock and branch operand readiness.
// Assumes: a load also writes its destination; register 0 is constant zero.
module hz_detect #(
    parameter int RIDX = 5
) (
    input  logic [RIDX-1:0] id_rs,
    input  logic [RIDX-1:0] id_rt,
    input  logic            id_use_rs,
    input  logic            id_use_rt,
    input  logic            id_is_branch,
    input  logic [RIDX-1:0] ex_rd,
    input  logic            ex_wen,
    input  logic            ex_load,
    input  logic [RIDX-1:0] mem_rd,
    input  logic            mem_load,
    output logic            stall
);
    logic ex_live, mem_ld_live;
    logic ex_hit, mem_hit;
    logic load_use, br_wait;

    // Qualify producers: nonzero destination only.
    always_comb begin
        ex_live     = (ex_wen || ex_load) && (ex_rd != '0);
        mem_ld_live = mem_load && (mem_rd != '0);
    end

    // Match producers against the decode sources.
    always_comb begin
        ex_hit  = (id_use_rs && id_rs == ex_rd) || (id_use_rt && id_rt == ex_rd);
        mem_hit = (id_rs == mem_rd) || (id_rt == mem_rd);
    end

    // Combine the load-use and branch-readiness conditions.
    always_comb begin
        load_use = ex_load && ex_live && ex_hit;
        br_wait  = id_is_branch &&
                   ((ex_live && ((id_rs == ex_rd) || (id_rt == ex_rd))) ||
                    (mem_ld_live && mem_hit));
        stall    = load_use || br_wait;
    end
endmodule

// File: rtl/fwd_pick.sv
// Operand source select for one execute-stage operand.
// Assumes: the memory-stage value is newer than the writeback value.
module fwd_pick #(
    parameter int RIDX = 5
) (
    input  logic [RIDX-1:0] src,
    input  logic [RIDX-1:0] mem_rd,
    input  logic            mem_wen,
    input  logic [RIDX-1:0] wb_rd,
    input  logic            wb_wen,
    output logic [1:0]      sel
);
    import pipe_ctl_pkg::*;

    // Priority pick: memory stage first, then writeback, then register file.
    always_comb begin
        if (src != '0 && mem_wen && mem_rd == src)
            sel = SRC_MEM;
        else if (src != '0 && wb_wen && wb_rd == src)
            sel = SRC_WB;
        else
            sel = SRC_RF;
    end
endmodule

// File: rtl/br_resolve.sv
// Decode-stage branch/jump resolution: comparator, its forwarding and targets.
// Assumes: pc is the address of the delay slot; branch and jump are exclusive.
module br_resolve #(
    parameter int XLEN = 32,
    parameter int RIDX = 5,
    parameter int IMMW = 16
) (
    input  logic [XLEN-1:0]   pc,
    input  logic              stall,
    input  logic [RIDX-1:0]   id_rs,
    input  logic [RIDX-1:0]   id_rt,
    input  logic              id_is_branch,
    input  logic              id_branch_ne,
    input  logic              id_is_jump,
    input  logic [IMMW-1:0]   id_imm,
    input  logic [XLEN-7:0]   id_jidx,
    input  logic [XLEN-1:0]   id_rs_data,
    input  logic [XLEN-1:0]   id_rt_data,
    input  logic [RIDX-1:0]   mem_rd,
    input  logic              mem_wen,
    input  logic              mem_load,
    input  logic [XLEN-1:0]   mem_result,
    output logic              cmp_fwd_a,
    output logic              cmp_fwd_b,
    output logic              taken,
    output logic [1:0]        next_sel,
    output logic [XLEN-1:0]   next_pc
);
    import pipe_ctl_pkg::*;
    localparam int EXTW = XLEN - IMMW;

    logic            mem_alu_live;
    logic [XLEN-1:0] opa, opb, imm_ext, br_tgt, jmp_tgt;
    logic            jump_go;

    // Comparator input forwarding from a non-load memory-stage result.
    always_comb begin
        mem_alu_live = mem_wen && !mem_load && (mem_rd != '0);
        cmp_fwd_a    = mem_alu_live && (mem_rd == id_rs);
        cmp_fwd_b    = mem_alu_live && (mem_rd == id_rt);
        opa          = cmp_fwd_a ? mem_result : id_rs_data;
        opb          = cmp_fwd_b ? mem_result : id_rt_data;
    end

    // Condition evaluation and target arithmetic.
    always_comb begin
        taken   = id_is_branch && !stall && ((opa == opb) ^ id_branch_ne);
        jump_go = id_is_jump && !id_is_branch && !stall;
        imm_ext = {{EXTW{id_imm[IMMW-1]}}, id_imm};
        br_tgt  = pc + (imm_ext << 2);
        jmp_tgt = {pc[XLEN-1:XLEN-4], id_jidx, 2'b00};
    end

    // Next-PC source choice.
    always_comb begin
        if (taken) begin
            next_sel = NS_BR;
            next_pc  = br_tgt;
        end else if (jump_go) begin
            next_sel = NS_JUMP;
            next_pc  = jmp_tgt;
        end else begin
            next_sel = NS_SEQ;
            next_pc  = pc + XLEN'(4);
        end
    end
endmodule

// File: rtl/pc_reg.sv
// Program counter register with hold.
// Assumes: synchronous active-low reset to address zero.
module pc_reg #(
    parameter int XLEN = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            hold,
    input  logic [XLEN-1:0] next_pc,
    output logic [XLEN-1:0] pc
);
    // Load the chosen next address unless held.
    always_ff @(posedge clk) begin
        if (!rst_n)
            pc <= '0;
        else if (!hold)
            pc <= next_pc;
    end
endmodule

// File: rtl/pipe_ctl.sv
// Hazard and branch control for a five-stage pipeline with one delay slot.
// Assumes: the datapath applies stall to its fetch/decode register and bubble
// to the execute-stage control flags; the register file is write-then-read.
module pipe_ctl #(
    parameter int XLEN = 32,
    parameter int RIDX = 5,
    parameter int IMMW = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [RIDX-1:0]   id_rs,
    input  logic [RIDX-1:0]   id_rt,
    input  logic              id_use_rs,
    input  logic              id_use_rt,
    input  logic              id_is_branch,
    input  logic              id_branch_ne,
    input  logic              id_is_jump,
    input  logic [IMMW-1:0]   id_imm,
    input  logic [XLEN-7:0]   id_jidx,
    input  logic [XLEN-1:0]   id_rs_data,
    input  logic [XLEN-1:0]   id_rt_data,
    input  logic [RIDX-1:0]   ex_rs,
    input  logic [RIDX-1:0]   ex_rt,
    input  logic [RIDX-1:0]   ex_rd,
    input  logic              ex_wen,
    input  logic              ex_load,
    input  logic [RIDX-1:0]   mem_rd,
    input  logic              mem_wen,
    input  logic              mem_load,
    input  logic [XLEN-1:0]   mem_result,
    input  logic [RIDX-1:0]   wb_rd,
    input  logic              wb_wen,
    output logic [XLEN-1:0]   pc,
    output logic [1:0]        next_sel,
    output logic              stall,
    output logic              bubble,
    output logic [1:0]        fwd_a,
    output logic [1:0]        fwd_b,
    output logic              cmp_fwd_a,
    output logic              cmp_fwd_b,
    output logic              branch_taken
);
    localparam int NSRC = 2;

    logic [XLEN-1:0] next_pc;
    logic [RIDX-1:0] ex_src [NSRC];
    logic [1:0]      ex_sel [NSRC];

    hz_detect #(.RIDX(RIDX)) u_hz (
        .id_rs(id_rs), .id_rt(id_rt),
        .id_use_rs(id_use_rs), .id_use_rt(id_use_rt),
        .id_is_branch(id_is_branch),
        .ex_rd(ex_rd), .ex_wen(ex_wen), .ex_load(ex_load),
        .mem_rd(mem_rd), .mem_load(mem_load),
        .stall(stall)
    );

    // Bubble accompanies every stall so the held decode slot issues nothing.
    always_comb bubble = stall;

    // Gather the execute-stage sources for the per-operand selectors.
    always_comb begin
        ex_src[0] = ex_rs;
        ex_src[1] = ex_rt;
    end

    for (genvar g = 0; g < NSRC; g++) begin : g_fwd
        fwd_pick #(.RIDX(RIDX)) u_pick (
            .src(ex_src[g]),
            .mem_rd(mem_rd), .mem_wen(mem_wen),
            .wb_rd(wb_rd), .wb_wen(wb_wen),
            .sel(ex_sel[g])
        );
    end

    // Drive the operand select ports.
    always_comb begin
        fwd_a = ex_sel[0];
        fwd_b = ex_sel[1];
    end

    br_resolve #(.XLEN(XLEN), .RIDX(RIDX), .IMMW(IMMW)) u_br (
        .pc(pc), .stall(stall),
        .id_rs(id_rs), .id_rt(id_rt),
        .id_is_branch(id_is_branch), .id_branch_ne(id_branch_ne),
        .id_is_jump(id_is_jump), .id_imm(id_imm), .id_jidx(id_jidx),
        .id_rs_data(id_rs_data), .id_rt_data(id_rt_data),
        .mem_rd(mem_rd), .mem_wen(mem_wen), .mem_load(mem_load),
        .mem_result(mem_result),
        .cmp_fwd_a(cmp_fwd_a), .cmp_fwd_b(cmp_fwd_b),
        .taken(branch_taken), .next_sel(next_sel), .next_pc(next_pc)
    );

    pc_reg #(.XLEN(XLEN)) u_pc (
        .clk(clk), .rst_n(rst_n), .hold(stall),
        .next_pc(next_pc), .pc(pc)
    );
endmodule

// File: rtl/pipe_ctl_chk.sv
// Property checker for pipe_ctl, attached by bind.
// Assumes: observes top-level ports only.
module pipe_ctl_chk #(
    parameter int XLEN = 32,
    parameter int RIDX = 5
) (
    input logic            clk,
    input logic            rst_n,
    input logic [XLEN-1:0] pc,
    input logic [1:0]      next_sel,
    input logic            stall,
    input logic            branch_taken,
    input logic [1:0]      fwd_a,
    input logic [RIDX-1:0] ex_rs,
    input logic            cmp_fwd_a,
    input logic [RIDX-1:0] id_rs
);
    a_r1_reset_zero: assert property (@(posedge clk)
        !rst_n |=> (pc == '0));

    a_r2_seq_step: assert property (@(posedge clk) disable iff (!rst_n)
        (!stall && next_sel == 2'd0) |=> (pc == $past(pc) + XLEN'(4)));

    a_r6_stall_hold: assert property (@(posedge clk) disable iff (!rst_n)
        stall |=> $stable(pc));

    a_r11_no_redirect: assert property (@(posedge clk) disable iff (!rst_n)
        stall |-> (next_sel == 2'd0 && !branch_taken));

    a_r9_legal_sel: assert property (@(posedge clk) disable iff (!rst_n)
        fwd_a != 2'd3);

    a_r10_zero_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        ((ex_rs == '0) |-> (fwd_a == 2'd0)) and ((id_rs == '0) |-> !cmp_fwd_a));
endmodule

bind pipe_ctl pipe_ctl_chk #(.XLEN(XLEN), .RIDX(RIDX)) u_chk (
    .clk(clk), .rst_n(rst_n), .pc(pc), .next_sel(next_sel),
    .stall(stall), .branch_taken(branch_taken), .fwd_a(fwd_a),
    .ex_rs(ex_rs), .cmp_fwd_a(cmp_fwd_a), .id_rs(id_rs)
);

// File: tb/pipe_ctl_tb.sv
`timescale 1ns/1ps
module pipe_ctl_tb;
    logic        clk = 0;
    logic        rst_n;
    logic [4:0]  id_rs, id_rt, ex_rs, ex_rt, ex_rd, mem_rd, wb_rd;
    logic        id_use_rs, id_use_rt, id_is_branch, id_branch_ne, id_is_jump;
    logic [15:0] id_imm;
    logic [25:0] id_jidx;
    logic [31:0] id_rs_data, id_rt_data, mem_result;
    logic        ex_wen, ex_load, mem_wen, mem_load, wb_wen;
    logic [31:0] pc;
    logic [1:0]  next_sel, fwd_a, fwd_b;
    logic        stall, bubble, cmp_fwd_a, cmp_fwd_b, branch_taken;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    pipe_ctl u_dut (.*);

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic idle();
        {id_rs, id_rt, ex_rs, ex_rt, ex_rd, mem_rd, wb_rd} = '0;
        {id_use_rs, id_use_rt, id_is_branch, id_branch_ne, id_is_jump} = '0;
        id_imm = '0; id_jidx = '0;
        id_rs_data = '0; id_rt_data = '0; mem_result = '0;
        {ex_wen, ex_load, mem_wen, mem_load, wb_wen} = '0;
    endtask

    // Advance one edge; inputs are applied at the preceding negedge.
    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        #900000;
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual hung expected finish");
            summary();
        end
    end

    initial begin
        idle();
        rst_n = 0;
        @(negedge clk);
        tick();
        chk("R1 reset pc", pc, 0);
        rst_n = 1;

        // R2: sequential flow
        for (int i = 1; i <= 3; i++) begin
            chk("R2 next_sel seq", 32'(next_sel), 0);
            tick();
            chk("R2 pc step", pc, 32'(4 * i));
        end

        // R3: beq taken, forward offset 3 words from pc 12
        id_is_branch = 1; id_rs = 1; id_rt = 2; id_use_rs = 1; id_use_rt = 1;
        id_rs_data = 7; id_rt_data = 7; id_imm = 16'd3;
        #0.5;
        chk("R3 beq next_sel", 32'(next_sel), 1);
        chk("R3 beq taken", 32'(branch_taken), 1);
        chk("R4 no bubble on branch", 32'(bubble), 0);
        tick();
        chk("R3 beq target", pc, 32'd24);

        // R3: bne taken, negative offset
        id_branch_ne = 1; id_rt_data = 8; id_imm = 16'hFFFE;
        tick();
        chk("R3 bne back target", pc, 32'd16);

        // R4: beq not taken
        id_branch_ne = 0;
        #0.5;
        chk("R4 not taken sel", 32'(next_sel), 0);
        chk("R4 not taken bubble", 32'(bubble), 0);
        tick();
        chk("R4 not taken pc", pc, 32'd20);

        // R5: jump
        idle(); id_is_jump = 1; id_jidx = 26'h40;
        #0.5;
        chk("R5 jump sel", 32'(next_sel), 2);
        tick();
        chk("R5 jump target", pc, 32'h100);

        // R6/R11: load-use stall with a true branch condition
        idle(); ex_load = 1; ex_wen = 1; ex_rd = 3;
        id_is_branch = 1; id_rs = 3; id_rt = 4; id_use_rs = 1; id_use_rt = 1;
        id_rs_data = 5; id_rt_data = 5; id_imm = 16'd1;
        #0.5;
        chk("R6 stall", 32'(stall), 1);
        chk("R6 bubble", 32'(bubble), 1);
        chk("R11 sel during stall", 32'(next_sel), 0);
        chk("R11 taken during stall", 32'(branch_taken), 0);
        tick();
        chk("R6 pc hold", pc, 32'h100);

        // R7: branch behind a load, two stall cycles
        ex_rd = 5; id_rs = 5; id_rt = 6;
        tick();
        chk("R7 load ex hold", pc, 32'h100);
        ex_load = 0; ex_wen = 0; ex_rd = 0; mem_load = 1; mem_wen = 1; mem_rd = 5;
        #0.5;
        chk("R7 load mem stall", 32'(stall), 1);
        tick();
        chk("R7 load mem hold", pc, 32'h100);
        mem_load = 0; mem_wen = 0; mem_rd = 0; wb_wen = 1; wb_rd = 5;
        #0.5;
        chk("R7 load wb resolves", 32'(stall), 0);
        tick();
        chk("R7 load branch target", pc, 32'h104);

        // R7/R8: branch behind ALU producer, one stall then comparator forward
        idle(); ex_wen = 1; ex_rd = 5;
        id_is_branch = 1; id_rs = 5; id_rt = 6; id_use_rs = 1; id_use_rt = 1;
        id_rs_data = 0; id_rt_data = 9; id_imm = 16'd2;
        #0.5;
        chk("R7 alu ex stall", 32'(stall), 1);
        tick();
        chk("R7 alu hold", pc, 32'h104);
        ex_wen = 0; ex_rd = 0; mem_wen = 1; mem_rd = 5; mem_result = 9;
        #0.5;
        chk("R8 cmp fwd a", 32'(cmp_fwd_a), 1);
        chk("R8 forwarded compare", 32'(branch_taken), 1);
        tick();
        chk("R8 target", pc, 32'h10C);

        // Sweep: load-use (R6, R10)
        idle();
        for (int ld = 0; ld < 2; ld++)
        for (int rd = 0; rd < 4; rd++)
        for (int rs = 0; rs < 4; rs++)
        for (int rt = 0; rt < 4; rt++)
        for (int u = 0; u < 4; u++) begin
            logic e;
            ex_load = ld[0]; ex_wen = ld[0]; ex_rd = 5'(rd);
            id_rs = 5'(rs); id_rt = 5'(rt); id_use_rs = u[0]; id_use_rt = u[1];
            #1;
            e = ld[0] && rd != 0 && ((u[0] && rs == rd) || (u[1] && rt == rd));
            chk("R6 R10 load-use sweep", 32'(stall), 32'(e));
        end

        // Sweep: branch readiness and comparator forwarding (R7, R8, R10)
        idle(); id_is_branch = 1; id_use_rs = 1; id_use_rt = 1;
        id_rs_data = 10; id_rt_data = 20; mem_result = 20;
        for (int ek = 0; ek < 3; ek++)
        for (int er = 0; er < 3; er++)
        for (int mk = 0; mk < 3; mk++)
        for (int mr = 0; mr < 3; mr++)
        for (int rs = 0; rs < 3; rs++)
        for (int rt = 0; rt < 3; rt++)
        for (int ne = 0; ne < 2; ne++) begin
            logic es, fa, fb, eq, tk;
            logic [31:0] a, b;
            ex_wen = ek != 0; ex_load = ek == 2; ex_rd = 5'(er);
            mem_wen = mk != 0; mem_load = mk == 2; mem_rd = 5'(mr);
            id_rs = 5'(rs); id_rt = 5'(rt); id_branch_ne = ne[0];
            #1;
            es = (ek != 0 && er != 0 && (rs == er || rt == er)) ||
                 (mk == 2 && mr != 0 && (rs == mr || rt == mr));
            fa = mk == 1 && mr != 0 && mr == rs;
            fb = mk == 1 && mr != 0 && mr == rt;
            a = fa ? 32'd20 : 32'd10;
            b = fb ? 32'd20 : 32'd20;
            eq = a == b;
            tk = !es && (eq ^ ne[0]);
            chk("R7 branch stall sweep", 32'(stall), 32'(es));
            chk("R8 R10 cmp fwd sweep", {30'b0, cmp_fwd_a, cmp_fwd_b}, {30'b0, fa, fb});
            chk("R3 R11 taken sweep", 32'(branch_taken), 32'(tk));
        end

        // Sweep: execute forwarding priority (R9, R10)
        idle();
        for (int s1 = 0; s1 < 4; s1++)
        for (int s2 = 0; s2 < 4; s2++)
        for (int m = 0; m < 4; m++)
        for (int w = 0; w < 4; w++)
        for (int en = 0; en < 4; en++) begin
            logic [1:0] ea, eb;
            ex_rs = 5'(s1); ex_rt = 5'(s2); mem_rd = 5'(m); wb_rd = 5'(w);
            mem_wen = en[0]; wb_wen = en[1];
            #1;
            ea = (s1 != 0 && en[0] && m == s1) ? 2'd1 :
                 (s1 != 0 && en[1] && w == s1) ? 2'd2 : 2'd0;
            eb = (s2 != 0 && en[0] && m == s2) ? 2'd1 :
                 (s2 != 0 && en[1] && w == s2) ? 2'd2 : 2'd0;
            chk("R9 R10 fwd sweep", {28'b0, fwd_a, fwd_b}, {28'b0, ea, eb});
        end

        // R1: reset during run
        idle();
        @(negedge clk);
        rst_n = 0;
        tick();
        chk("R1 mid-run reset", pc, 0);
        rst_n = 1;

        done = 1;
        summary();
    end
endmodule